// File: doc/BRIEF.md
# PDM Transmit Output Stage

This block turns a stereo stream of 16-bit PCM samples into pulse-density-modulated bitstreams. Each accepted sample pair is held for a programmable number of modulator steps, which gives a zero-order-hold up-sampler whose ratio is a numerator over a denominator. Each slot then feeds a first-order sigma-delta modulator whose output density of ones follows the sample value.

The modulated bits leave the block in one of three line arrangements. Codec mode puts both slots on one data line next to a PDM clock, with the clock level telling them apart. The two DAC modes leave the clock idle and drive either one line or one line per slot, for a power stage followed by an external low-pass filter. A mono control and a clock-invert control handle single-slot use. When the next sample is needed but not offered, the block keeps the old one and raises an underrun flag.

Top module: `pdm_tx_stage`

## Requirements
- R1: A sample pair is taken when `pcm_ready` and `pcm_valid` are both high on a clock edge. `pcm_ready` is a pulse one cycle wide. The taken values drive the modulators until the next pair is taken.
- R2: One sample is requested every 64 × `ratio_num` / `ratio_den` modulator steps, averaged over a long run. So 960/480 gives 128 steps per sample, 960/960 gives 64, and 1000/768 gives 83⅓.
- R3: One modulator step happens every PDM clock period. That period is 2 × HALF_DIV system clocks, and in codec mode `pdm_clk` has exactly one rising edge per period.
- R4: Over N steps of a constant input x (signed two's complement), the number of one bits is within 3 of N·(x+32768)/65536.
- R5: The modulator accumulators stay within ±2×32768 for every input, the full-scale limits included. An input of −32768 gives almost no ones and 32767 gives almost all ones.
- R6: In codec mode (`line_mode` = 0), `pdm_dat0` carries the left-slot bit while `pdm_clk` is high and the right-slot bit while it is low.
- R7: In both DAC modes (`line_mode` = 1 or 2, and the spare code 3), `pdm_clk` is held low.
- R8: In one-line DAC mode (`line_mode` = 1), `pdm_dat0` carries the left slot. In every mode other than two-line DAC, `pdm_dat1` is held low.
- R9: In two-line DAC mode (`line_mode` = 2), `pdm_dat0` carries the left slot and `pdm_dat1` carries the right slot.
- R10: With `mono` = 1, `pcm_right` is ignored. In codec mode the right half-period carries a zero-code stream with a density of 1/2. In two-line DAC mode both lines carry the left sample.
- R11: In codec mode `clk_inv` = 1 inverts `pdm_clk`. In mono this moves the left sample into the half-period where the clock is low, which is the right-slot position.
- R12: A request with `pcm_valid` low sets `underrun`, and the modulators keep the last sample while new input values are ignored. The next accepted pair clears `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_mode | input | 2 | 0 codec one line, 1 DAC one line, 2 DAC two lines |
| mono | input | 1 | Single-slot operation from the left sample |
| clk_inv | input | 1 | Invert the PDM clock in codec mode |
| ratio_num | input | 16 | Up-sampling numerator |
| ratio_den | input | 16 | Up-sampling denominator, non-zero |
| pcm_valid | input | 1 | A sample pair is offered |
| pcm_ready | output | 1 | One-cycle request for the next sample pair |
| pcm_left | input | 16 | Left sample, signed |
| pcm_right | input | 16 | Right sample, signed |
| pdm_clk | output | 1 | PDM clock in codec mode, low otherwise |
| pdm_dat0 | output | 1 | First PDM data line |
| pdm_dat1 | output | 1 | Second PDM data line (two-line DAC mode) |
| underrun | output | 1 | The last request found no sample |

## Verification
The bench builds the block with HALF_DIV = 2. One modulator step then takes four system clocks, so a window of 1024 steps fits in about four thousand cycles. This makes it cheap to compare the ones density against the closed form for many random sample values in every line mode. The ratio pairs 960/480, 960/960 and 1000/768 each finish dozens of sample requests within ten thousand cycles, and the last pair exercises the fractional remainder in the request counter.

// File: rtl/pdm_tx_pkg.sv
// Shared definitions for the PDM transmit stage.
// Assumes samples are 16-bit signed and one sample period spans 64 x ratio steps.
package pdm_tx_pkg;
    typedef enum logic [1:0] {
        LM_CODEC = 2'b00,
        LM_DAC1  = 2'b01,
        LM_DAC2  = 2'b10,
        LM_SPARE = 2'b11
    } line_mode_e;

    localparam int PCM_W    = 16;
    localparam int OSR_LOG2 = 6;
endpackage

// File: rtl/pdm_tx_clkgen.sv
// PDM bit-clock generator: divides the system clock by 2*HALF_DIV.
// step pulses for one cycle on the edge where phase goes high.
// Assumes HALF_DIV >= 1.
module pdm_tx_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase,
    output logic step
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          term;

    assign term = (cnt == CW'(HALF_DIV - 1));
    assign step = term & ~phase;

    // Half-period counter and clock phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (term) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: every step opens the high half of the PDM period
    assert_step_opens_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> phase);
    // R3: the phase only rises on a step
    assert_rise_needs_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase) |-> $past(step));
endmodule

// File: rtl/pdm_tx_upsampler.sv
// Zero-order-hold up-sampler with a fractional request counter.
// A sample is requested every 64*num/den steps. The held pair drives the modulators.
// Assumes ratio_den is non-zero and not above 64*ratio_num.
module pdm_tx_upsampler
    import pdm_tx_pkg::*;
#(
    parameter int NUM_W = 16,
    parameter int SW    = PCM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [NUM_W-1:0] ratio_num,
    input  logic [NUM_W-1:0] ratio_den,
    input  logic          pcm_valid,
    input  logic [SW-1:0] pcm_left,
    input  logic [SW-1:0] pcm_right,
    output logic          pcm_ready,
    output logic [SW-1:0] hold_left,
    output logic [SW-1:0] hold_right,
    output logic          underrun
);
    localparam int PW = NUM_W + OSR_LOG2 + 1;

    logic [PW-1:0] ph;
    logic [PW-1:0] sum;
    logic [PW-1:0] thr;
    logic          wrap;

    assign thr  = PW'({ratio_num, {OSR_LOG2{1'b0}}});
    assign sum  = ph + PW'(ratio_den);
    assign wrap = (sum >= thr);

    // Fractional phase: request a new sample when the threshold is crossed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= '0;
            pcm_ready <= 1'b0;
        end else begin
            pcm_ready <= 1'b0;
            if (step) begin
                if (wrap) begin
                    ph        <= sum - thr;
                    pcm_ready <= 1'b1;
                end else begin
                    ph <= sum;
                end
            end
        end
    end

    // Sample hold and underrun tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_left  <= '0;
            hold_right <= '0;
            underrun   <= 1'b0;
        end else if (pcm_ready) begin
            if (pcm_valid) begin
                hold_left  <= pcm_left;
                hold_right <= pcm_right;
                underrun   <= 1'b0;
            end else begin
                underrun <= 1'b1;
            end
        end
    end

    // R1: the request is a single-cycle pulse
    assert_ready_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_ready |=> !pcm_ready);
    // R1: an accepted pair is what the modulators see next
    assert_take_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_ready && pcm_valid) |=> (hold_left == $past(pcm_left)) && (hold_right == $past(pcm_right)));
    // R12: a missed request flags underrun
    assert_underrun_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_ready && !pcm_valid) |=> underrun);
    // R12: during underrun the held sample does not move
    assert_underrun_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !pcm_ready) |=> $stable(hold_left) && $stable(hold_right));
endmodule

// File: rtl/pdm_tx_sdm.sv
// First-order sigma-delta modulator for one slot.
// Output bit = accumulator non-negative; feedback is +/- full scale.
// Assumes ACC_W >= SW + 2 so full-scale input cannot overflow the accumulator.
module pdm_tx_sdm #(
    parameter int SW    = 16,
    parameter int ACC_W = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic signed [SW-1:0] din,
    output logic                 bit_o
);
    localparam logic signed [ACC_W-1:0] FS_V = ACC_W'(1 << (SW - 1));
    localparam logic signed [ACC_W-1:0] LIM  = ACC_W'(1 << SW);

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] din_x;
    logic signed [ACC_W-1:0] acc_n;
    logic                    bit_now;

    assign din_x   = {{(ACC_W - SW){din[SW-1]}}, din};
    assign bit_now = ~acc[ACC_W-1];
    assign acc_n   = bit_now ? (acc + din_x - FS_V) : (acc + din_x + FS_V);

    // Integrate the error once per modulator step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            bit_o <= 1'b0;
        end else if (step) begin
            acc   <= acc_n;
            bit_o <= bit_now;
        end
    end

    // R5: the accumulator stays inside twice full scale
    assert_acc_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc >= -LIM) && (acc < LIM));
endmodule

// File: rtl/pdm_tx_stage.sv
// PDM transmit output stage: up-sampler, two sigma-delta slots, line mapping.
// Codec mode muxes both slots on one line by clock level; DAC modes are clockless.
// Assumes configuration inputs are held steady between resets.
module pdm_tx_stage
    import pdm_tx_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int NUM_W    = 16,
    parameter int ACC_W    = PCM_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       line_mode,
    input  logic             mono,
    input  logic             clk_inv,
    input  logic [NUM_W-1:0] ratio_num,
    input  logic [NUM_W-1:0] ratio_den,
    input  logic             pcm_valid,
    output logic             pcm_ready,
    input  logic [PCM_W-1:0] pcm_left,
    input  logic [PCM_W-1:0] pcm_right,
    output logic             pdm_clk,
    output logic             pdm_dat0,
    output logic             pdm_dat1,
    output logic             underrun
);
    logic             phase;
    logic             step;
    logic [PCM_W-1:0] hold_left;
    logic [PCM_W-1:0] hold_right;
    logic [PCM_W-1:0] slot_b_in;
    logic             bit_a;
    logic             bit_b;
    logic             is_codec;
    logic             two_line;

    assign is_codec = (line_mode == LM_CODEC);
    assign two_line = (line_mode == LM_DAC2);

    pdm_tx_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .step  (step)
    );

    pdm_tx_upsampler #(.NUM_W(NUM_W), .SW(PCM_W)) u_upsamp (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .ratio_num  (ratio_num),
        .ratio_den  (ratio_den),
        .pcm_valid  (pcm_valid),
        .pcm_left   (pcm_left),
        .pcm_right  (pcm_right),
        .pcm_ready  (pcm_ready),
        .hold_left  (hold_left),
        .hold_right (hold_right),
        .underrun   (underrun)
    );

    // Slot B source: right sample, or zero code / left copy in mono.
    always_comb begin
        if (!mono)         slot_b_in = hold_right;
        else if (is_codec) slot_b_in = '0;
        else               slot_b_in = hold_left;
    end

    pdm_tx_sdm #(.SW(PCM_W), .ACC_W(ACC_W)) u_sdm_a (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .din   (hold_left),
        .bit_o (bit_a)
    );

    pdm_tx_sdm #(.SW(PCM_W), .ACC_W(ACC_W)) u_sdm_b (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .din   (slot_b_in),
        .bit_o (bit_b)
    );

    // Line mapping for the three output arrangements.
    always_comb begin
        pdm_clk  = is_codec & (phase ^ clk_inv);
        pdm_dat0 = is_codec ? (phase ? bit_a : bit_b) : bit_a;
        pdm_dat1 = two_line & bit_b;
    end

    // R7: a clockless mode keeps the clock line low
    assert_dac_no_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_codec && $stable(line_mode)) |=> !pdm_clk);
    // R8: the second line is quiet outside two-line mode
    assert_dat1_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!two_line && $stable(line_mode)) |=> !pdm_dat1);
    // R6: right after a step the clock shows the left half
    assert_codec_left_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_codec && step && $stable(clk_inv)) |=> (pdm_clk != clk_inv) && (pdm_dat0 == bit_a));
endmodule

// File: tb/pdm_tx_stage_tb.sv
module pdm_tx_stage_tb;
    localparam int HALF = 2;
    localparam int WIN  = 4096;
    localparam int NSTP = WIN / (2 * HALF);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  line_mode = 2'd0;
    logic        mono = 1'b0;
    logic        clk_inv = 1'b0;
    logic [15:0] ratio_num = 16'd960;
    logic [15:0] ratio_den = 16'd960;
    logic        pcm_valid = 1'b1;
    logic        pcm_ready;
    logic [15:0] pcm_left = '0;
    logic [15:0] pcm_right = '0;
    logic        pdm_clk, pdm_dat0, pdm_dat1, underrun;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    pdm_tx_stage #(.HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_mode(line_mode), .mono(mono),
        .clk_inv(clk_inv), .ratio_num(ratio_num), .ratio_den(ratio_den),
        .pcm_valid(pcm_valid), .pcm_ready(pcm_ready), .pcm_left(pcm_left),
        .pcm_right(pcm_right), .pdm_clk(pdm_clk), .pdm_dat0(pdm_dat0),
        .pdm_dat1(pdm_dat1), .underrun(underrun)
    );

    function automatic int exp_ones(int steps, int x);
        return (steps * (x + 32768)) / 65536;
    endfunction

    task automatic check_near(string tag, int act, int expv, int tol);
        n_tests++;
        if (act > expv + tol || act < expv - tol) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (+/-%0d)", tag, act, expv, tol);
        end
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic setup(logic [1:0] m, logic mo, logic inv, int num, int den);
        @(negedge clk);
        rst_n = 1'b0; line_mode = m; mono = mo; clk_inv = inv;
        ratio_num = 16'(num); ratio_den = 16'(den); pcm_valid = 1'b1;
        wait_cyc(4);
        rst_n = 1'b1;
    endtask

    task automatic set_pcm(int l, int r);
        pcm_left = 16'(l); pcm_right = 16'(r);
    endtask

    task automatic measure(int cycles, output int hi1, output int lo1,
                           output int d0, output int d1, output int rises, output int acc);
        logic prev;
        hi1 = 0; lo1 = 0; d0 = 0; d1 = 0; rises = 0; acc = 0;
        prev = pdm_clk;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pdm_clk && pdm_dat0)  hi1++;
            if (!pdm_clk && pdm_dat0) lo1++;
            d0 += int'(pdm_dat0);
            d1 += int'(pdm_dat1);
            if (pdm_clk && !prev) rises++;
            prev = pdm_clk;
            if (pcm_ready && pcm_valid) acc++;
        end
    endtask

    initial begin : watchdog
        while (cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int hi1, lo1, d0, d1, rises, acc, l, r;
        void'($urandom(32'd1234));

        // Reset state
        wait_cyc(3);
        check_near("R3 reset pdm_clk", int'(pdm_clk), 0, 0);
        check_near("R8 reset pdm_dat1", int'(pdm_dat1), 0, 0);
        check_near("R12 reset underrun", int'(underrun), 0, 0);
        check_near("R1 reset pcm_ready", int'(pcm_ready), 0, 0);

        // R3: clock rate and R2: request rate for three ratios
        setup(2'd0, 1'b0, 1'b0, 960, 480);
        set_pcm(0, 0);
        measure(10240, hi1, lo1, d0, d1, rises, acc);
        check_near("R3 clock rises", rises, 10240 / (2 * HALF), 1);
        check_near("R2 requests 960/480", acc, 10240 / (128 * 2 * HALF), 1);
        setup(2'd0, 1'b0, 1'b0, 960, 960);
        measure(10240, hi1, lo1, d0, d1, rises, acc);
        check_near("R2 requests 960/960", acc, 10240 / (64 * 2 * HALF), 1);
        setup(2'd0, 1'b0, 1'b0, 1000, 768);
        measure(10000, hi1, lo1, d0, d1, rises, acc);
        check_near("R2 requests 1000/768", acc, (10000 / (2 * HALF)) * 768 / (64 * 1000), 1);

        // R4 R6 R1: codec stereo, random samples
        setup(2'd0, 1'b0, 1'b0, 960, 960);
        for (int t = 0; t < 5; t++) begin
            l = int'($urandom_range(65535)) - 32768;
            r = int'($urandom_range(65535)) - 32768;
            set_pcm(l, r);
            wait_cyc(700);
            measure(WIN, hi1, lo1, d0, d1, rises, acc);
            check_near("R6 codec left half density", hi1 / HALF, exp_ones(NSTP, l), 3);
            check_near("R4 codec right half density", lo1 / HALF, exp_ones(NSTP, r), 3);
            check_near("R8 codec dat1 quiet", d1, 0, 0);
        end

        // R5 R9: full scale on two lines
        setup(2'd2, 1'b0, 1'b0, 960, 960);
        set_pcm(32767, -32768);
        wait_cyc(700);
        measure(WIN, hi1, lo1, d0, d1, rises, acc);
        check_near("R5 full scale positive", d0 / (2 * HALF), exp_ones(NSTP, 32767), 3);
        check_near("R5 full scale negative", d1 / (2 * HALF), exp_ones(NSTP, -32768), 3);
        check_near("R7 two-line no clock", rises, 0, 0);

        // R9: random two-line
        for (int t = 0; t < 3; t++) begin
            l = int'($urandom_range(65535)) - 32768;
            r = int'($urandom_range(65535)) - 32768;
            set_pcm(l, r);
            wait_cyc(700);
            measure(WIN, hi1, lo1, d0, d1, rises, acc);
            check_near("R9 line0 left", d0 / (2 * HALF), exp_ones(NSTP, l), 3);
            check_near("R9 line1 right", d1 / (2 * HALF), exp_ones(NSTP, r), 3);
        end

        // R7 R8: one-line DAC
        setup(2'd1, 1'b0, 1'b0, 960, 960);
        set_pcm(-12000, 25000);
        wait_cyc(700);
        measure(WIN, hi1, lo1, d0, d1, rises, acc);
        check_near("R7 one-line dac clock low", hi1 + rises, 0, 0);
        check_near("R8 one-line dac dat1 low", d1, 0, 0);
        check_near("R8 one-line dac left", d0 / (2 * HALF), exp_ones(NSTP, -12000), 3);

        // R10: mono codec and mono two-line
        setup(2'd0, 1'b1, 1'b0, 960, 960);
        set_pcm(28000, -30000);
        wait_cyc(700);
        measure(WIN, hi1, lo1, d0, d1, rises, acc);
        check_near("R10 mono codec left half", hi1 / HALF, exp_ones(NSTP, 28000), 3);
        check_near("R10 mono codec zero half", lo1 / HALF, NSTP / 2, 3);
        setup(2'd2, 1'b1, 1'b0, 960, 960);
        set_pcm(-20000, 30000);
        wait_cyc(700);
        measure(WIN, hi1, lo1, d0, d1, rises, acc);
        check_near("R10 mono dac line0", d0 / (2 * HALF), exp_ones(NSTP, -20000), 3);
        check_near("R10 mono dac line1 copies left", d1 / (2 * HALF), exp_ones(NSTP, -20000), 3);

        // R11: clock invert in mono codec
        setup(2'd0, 1'b1, 1'b1, 960, 960);
        set_pcm(28000, -30000);
        wait_cyc(700);
        measure(WIN, hi1, lo1, d0, d1, rises, acc);
        check_near("R11 inverted left in low half", lo1 / HALF, exp_ones(NSTP, 28000), 3);
        check_near("R11 inverted zero in high half", hi1 / HALF, NSTP / 2, 3);
        check_near("R11 inverted clock rate", rises, NSTP, 1);

        // R12: underrun
        setup(2'd2, 1'b0, 1'b0, 960, 960);
        set_pcm(20000, -20000);
        wait_cyc(700);
        pcm_valid = 1'b0;
        set_pcm(-30000, 30000);
        wait_cyc(300);
        check_near("R12 underrun raised", int'(underrun), 1, 0);
        measure(WIN, hi1, lo1, d0, d1, rises, acc);
        check_near("R12 last left kept", d0 / (2 * HALF), exp_ones(NSTP, 20000), 3);
        check_near("R12 last right kept", d1 / (2 * HALF), exp_ones(NSTP, -20000), 3);
        pcm_valid = 1'b1;
        wait_cyc(300);
        check_near("R12 underrun cleared", int'(underrun), 0, 0);
        wait_cyc(400);
        measure(WIN, hi1, lo1, d0, d1, rises, acc);
        check_near("R12 new left after recovery", d0 / (2 * HALF), exp_ones(NSTP, -30000), 3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule